// File: doc/BRIEF.md
# Masked-Write Programmable Clock Divider

This block holds the control state for a small clock generator and runs the integer dividers that this state programs. Software writes 32-bit words over a plain write port. The upper half-word of each write is a per-bit enable for the lower half-word, so one write can change a single field and leave every other bit alone. No read-modify-write is needed.

Three dividers run from the fast source clock `clk`. Each divider divides by its stored ratio field plus one. Each one gives two outputs. The first is a one-cycle strobe per output period, for use as a clock enable. The second is a registered level that serves as the divided clock. A new ratio is taken up only at the end of the output period in progress. A run-time change therefore never shortens or splits a phase.

A two-bit source-select field sits in the same register space and is brought out for the clock mux outside this block. The write port has no back-pressure: every cycle with `wr_en` high commits one write, and there is no ready signal.

Top module: `mcd_top`

## Requirements
- R1: On a write, bit k of the addressed register (k in 0..15) takes wr_data[k] when wr_data[16+k] is 1 and keeps its old value when wr_data[16+k] is 0. The new value is visible to the dividers from the next clock edge on.
- R2: A write whose mask half-word wr_data[31:16] is zero changes no stored bit, so no output differs from a run without that write.
- R3: A divider whose active ratio is N asserts its strobe for one cycle out of every N+1 source cycles. With N = 0 the strobe is high on every cycle.
- R4: For a division D = N+1 of 2 or more, the level output is high for floor(D/2) cycles at the start of each period and low for the remaining ceil(D/2) cycles. The strobe falls on the last low cycle. For odd D, the high phase is one cycle shorter than the low phase.
- R5: A ratio written in the middle of a period becomes active only on the cycle after that period's strobe. Every period completes at its old length. If several writes land within one period, only the value stored at the period's last cycle is taken up.
- R6: After reset, both registers read as zero. Every strobe and every level output is high on every cycle (source rate), and the select output is 0.
- R7: Field positions: divider 0 uses register 0 bits [5:0], divider 1 uses register 0 bits [15:10], divider 2 uses register 1 bits [10:6], and the source select uses register 1 bits [13:12].
- R8: A write to one register address leaves the other register, and the dividers it feeds, unchanged.
- R9: The source-select output follows its stored field one cycle after the write. Changing it leaves the ratio fields alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock for the registers and all dividers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Commit a write this cycle |
| wr_addr | input | 1 | Register index (0 or 1) |
| wr_data | input | 32 | [31:16] bit-enable mask, [15:0] data |
| src_sel_o | output | 2 | Stored source-select field |
| div_tick_o | output | 3 | Per-divider end-of-period strobe |
| div_clk_o | output | 3 | Per-divider registered divided clock level |

## Verification
The bench goes after ratio changes written in the middle of a period, including two writes inside one period. A design that switched ratio at once would emit a short or split phase, and one that latched the first write would run at a stale ratio. It covers odd and even divisions: a design with the wrong duty split would put the strobe on a high cycle or stretch the wrong phase. It also covers partial masks that touch a single bit of a field, the all-zero mask, and writes to the register that a divider does not use. A merge that ignored the mask, or an address decode that wrote both registers, would change a divider that must keep its period. Ratio 0 checks that the outputs stay at source rate rather than stalling.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int REG_N   = 2;
  localparam int REG_AW  = (REG_N > 1) ? $clog2(REG_N) : 1;
  localparam int HALF_W  = 16;
  localparam int BUS_W   = 2 * HALF_W;
  localparam int DIV_N   = 3;
  localparam int SEL_REG = 1;
  localparam int SEL_LSB = 12;
  localparam int SEL_W   = 2;

  // register index that holds the ratio of divider i
  function automatic int fld_reg(input int i);
    case (i)
      0:       return 0;
      1:       return 0;
      default: return 1;
    endcase
  endfunction

  // lowest bit of divider i's ratio field
  function automatic int fld_lsb(input int i);
    case (i)
      0:       return 0;
      1:       return 10;
      default: return 6;
    endcase
  endfunction

  // width of divider i's ratio field
  function automatic int fld_w(input int i);
    case (i)
      0:       return 6;
      1:       return 6;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/mcd_regbank.sv
module mcd_regbank
  import mcd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [REG_AW-1:0]            wr_addr,
  input  logic [BUS_W-1:0]             wr_data,
  output logic [REG_N-1:0][HALF_W-1:0] regs_o
);
  logic [HALF_W-1:0] wmask;
  logic [HALF_W-1:0] wval;

  assign wmask = wr_data[BUS_W-1:HALF_W];
  assign wval  = wr_data[HALF_W-1:0];

  for (genvar r = 0; r < REG_N; r++) begin : g_reg
    logic              hit;
    logic [HALF_W-1:0] merged;
    assign hit    = wr_en && (wr_addr == REG_AW'(r));
    assign merged = (regs_o[r] & ~wmask) | (wval & wmask);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_o[r] <= '0;
      else if (hit) regs_o[r] <= merged;
    end
  end

  AST_ZERO_MASK_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wmask == '0) |=> $stable(regs_o)); // R2

  AST_MASKED_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((regs_o[$past(wr_addr)] ^ $past(regs_o[wr_addr])) & ~$past(wmask)) == '0)); // R1

  AST_UNMASKED_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((regs_o[$past(wr_addr)] ^ $past(wval)) & $past(wmask)) == '0)); // R1
endmodule

// File: rtl/mcd_divider.sv
module mcd_divider #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_i,
  output logic          tick_o,
  output logic          clk_o
);
  logic [RW-1:0] cnt_q, act_q;
  logic [RW-1:0] cnt_d, act_d;
  logic [RW:0]   half_d;
  logic          wrap, tick_d, level_d;

  always_comb begin
    wrap    = (cnt_q == act_q);
    cnt_d   = wrap ? '0 : cnt_q + RW'(1);
    act_d   = wrap ? ratio_i : act_q;
    half_d  = ({1'b0, act_d} + (RW+1)'(1)) >> 1;
    tick_d  = (cnt_d == act_d);
    level_d = (act_d == '0) || ({1'b0, cnt_d} < half_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= '0;
      tick_o <= 1'b1;
      clk_o  <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      tick_o <= tick_d;
      clk_o  <= level_d;
    end
  end

  AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(cnt_q == act_q)); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q); // R3

  AST_TICK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != '0 && tick_o) |-> !clk_o); // R4

  AST_SOURCE_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |-> (tick_o && clk_o)); // R3
endmodule

// File: rtl/mcd_top.sv
module mcd_top
  import mcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic [SEL_W-1:0] src_sel_o,
  output logic [DIV_N-1:0] div_tick_o,
  output logic [DIV_N-1:0] div_clk_o
);
  logic [REG_N-1:0][HALF_W-1:0] regs;
  logic                         unused_reg_bits;

  mcd_regbank u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  assign unused_reg_bits = ^regs;
  assign src_sel_o       = regs[SEL_REG][SEL_LSB +: SEL_W];

  for (genvar g = 0; g < DIV_N; g++) begin : g_div
    localparam int W   = fld_w(g);
    localparam int RIX = fld_reg(g);
    localparam int LSB = fld_lsb(g);
    mcd_divider #(.RW(W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .ratio_i (regs[RIX][LSB +: W]),
      .tick_o  (div_tick_o[g]),
      .clk_o   (div_clk_o[g])
    );
  end

  AST_SEL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(src_sel_o)); // R9
endmodule

// File: tb/mcd_top_tb.sv
`timescale 1ns/1ps
module mcd_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  src_sel_o;
  logic [2:0]  div_tick_o, div_clk_o;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  string cur_req = "R6";

  int          m_cnt [3];
  int          m_act [3];
  logic [15:0] m_reg [2];

  always #4 clk = ~clk;

  mcd_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_sel_o(src_sel_o),
    .div_tick_o(div_tick_o), .div_clk_o(div_clk_o)
  );

  // ratio field per divider (R7 positions)
  function automatic int ratio_of(input int d);
    case (d)
      0:       return int'(m_reg[0][5:0]);
      1:       return int'(m_reg[0][15:10]);
      default: return int'(m_reg[1][10:6]);
    endcase
  endfunction

  task automatic model_step();
    for (int d = 0; d < 3; d++) begin
      if (m_cnt[d] == m_act[d]) begin
        m_cnt[d] = 0;
        m_act[d] = ratio_of(d);
      end else m_cnt[d] = m_cnt[d] + 1;
    end
    if (wr_en)
      m_reg[wr_addr] = (m_reg[wr_addr] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [2:0] et, ec;
    for (int d = 0; d < 3; d++) begin
      et[d] = (m_cnt[d] == m_act[d]);
      ec[d] = (m_act[d] == 0) || (m_cnt[d] < (m_act[d] + 1) / 2);
    end
    check(cur_req, int'({src_sel_o, div_tick_o, div_clk_o}),
          int'({m_reg[1][13:12], et, ec}), "sel/tick/level");
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input int a, input logic [31:0] x);
    wr_en = 1'b1; wr_addr = 1'(a); wr_data = x;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    for (int d = 0; d < 3; d++) begin m_cnt[d] = 0; m_act[d] = 0; end
    m_reg[0] = '0; m_reg[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R6";                              // R6 reset state, source rate
    compare();
    run(6);

    cur_req = "R1";                              // R1 / R7 divider 0 field /12
    wr(0, 32'h003f_000b);
    run(40);

    cur_req = "R7";                              // R7 divider 1 field value 3 -> /4
    wr(0, 32'hfc00_0c00);
    run(30);

    cur_req = "R4";                              // R4 odd divide /5 on divider 2
    wr(1, 32'h07c0_0100);
    run(12);
    begin                                        // R3 ten strobes in 50 cycles at /5
      int ticks = 0;
      for (int i = 0; i < 50; i++) begin cyc(); if (div_tick_o[2]) ticks++; end
      check("R3", ticks, 10, "divider 2 strobes over 50 cycles");
    end

    cur_req = "R2";                              // R2 zero mask write is a no-op
    wr(0, 32'h0000_ffff);
    wr(1, 32'h0000_ffff);
    run(30);

    cur_req = "R9";                              // R9 select change only
    wr(1, 32'h3000_2000);
    check("R9", int'(src_sel_o), 2, "select after write");
    run(20);

    cur_req = "R8";                              // R8 reg1 write leaves reg0 dividers
    wr(1, 32'h07c0_0080);
    run(30);

    cur_req = "R5";                              // R5 mid-period ratio changes
    wr(0, 32'h003f_0005);
    run(3);
    wr(0, 32'h003f_0002);
    run(2);
    wr(0, 32'h003f_0007);
    wr(0, 32'h003f_0001);
    run(40);

    cur_req = "R1";                              // R1 single-bit mask on divider 2 field
    wr(1, 32'h0040_ffff);
    run(30);

    cur_req = "R3";                              // R3 back to source rate
    wr(0, 32'hffff_0000);
    wr(1, 32'h07c0_0000);
    run(30);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule